// File: doc/BRIEF.md
# Segmented Memory Write Router

The router sits between a 16-bit host bus and a set of on-chip memories. Each host write carries a 16-bit address and a 16-bit data word. The router decodes the address and steers the word to one of these targets:

- an internal control register file;
- a per-element phase offset table;
- a clock configuration table;
- one of two modulation buffers;
- a paged duty lookup table;
- one of two paged sequence buffers.

Four registers in the internal file select which buffer is written and which page is written. With them, the 14-bit in-region offset reaches memories larger than the bus can address. Software can therefore fill the idle half of a double-buffered memory while the other half is in use.

Writes leave the router as registered strobes, one cycle after the host strobe. Each strobe has its own widened address and shares a common data output. Reads are served only from the internal register file, with a fixed one-cycle latency. A write that cannot be placed is dropped and raises a sticky error flag. This covers an undefined control sub-region, a buffer index out of range and a page out of range.

Top module: `bram_write_router`

## Requirements
- R1: Address bits [15:14] pick the region: 0 control, 1 modulation, 2 duty table, 3 sequence. Bits [13:0] are the offset inside the region.
- R2: In the control region, offset bits [13:8] pick the sub-table: 0 internal register file, 1 phase table (`phase_we`), 2 clock table (`clkcfg_we`). `sub_addr` carries offset bits [7:0].
- R3: A write to control sub-table 0 stores the word at index bits [7:0] of the internal register file. All entries reset to zero.
- R4: A modulation write raises `mod_we[s]`. Here s is the value of register 0x10, and `mod_addr` equals the 14-bit offset.
- R5: A sequence write raises `seq_we[s]`. Here s is the value of register 0x11, and `seq_addr` equals (register 0x12 << 14) | offset.
- R6: A duty write raises `duty_we`, and `duty_addr` equals (register 0x13 << 14) | offset.
- R7: A read strobe gives `host_rvalid` one cycle later. At that point `host_rdata` holds the register file entry for a control sub-table 0 address, and zero for any other address.
- R8: A write is dropped and `wr_error` is set in either of two cases. The first is a control sub-table code other than 0..2. The second is a buffer register value of 2 or more, or a page above the page range (16 sequence pages, 2 duty pages). `wr_error` then stays set until reset.
- R9: Write strobes appear exactly one cycle after `host_wr_en`. At most one strobe is high in any cycle, and none is high without a preceding host write. `mem_wdata` carries the written word.
- R10: A change to a buffer or page register applies to a write issued on the very next cycle.
- R11: After reset every strobe is low, `wr_error` and `host_rvalid` are low, and all selection registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 16 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd_en |
| phase_we | output | 1 | Phase table write enable |
| clkcfg_we | output | 1 | Clock configuration table write enable |
| sub_addr | output | 8 | Address for phase and clock tables |
| mod_we | output | NUM_SEG | Modulation buffer write enables |
| mod_addr | output | 14 | Modulation buffer address |
| duty_we | output | 1 | Duty table write enable |
| duty_addr | output | 14+DUTY_PAGE_W | Duty table address |
| seq_we | output | NUM_SEG | Sequence buffer write enables |
| seq_addr | output | 14+SEQ_PAGE_W | Sequence buffer address |
| mem_wdata | output | 16 | Write data to all memories |
| wr_error | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the router with the default values: two buffers, four sequence page bits and one duty page bit. With these values, page values of 16 and above and a duty page of 2 are out of range, so the dropped-write path is reached with small register values. The largest page shifts fill the widened addresses to their top bits. The random mix writes buffer and page values just past their limits and uses the undefined control sub-table code 3. It then issues writes in the cycle right after a register update, which tests both the error flag and the next-cycle effect of each register.

// File: rtl/router_pkg.sv
package router_pkg;

    localparam int HOST_DW = 16;
    localparam int OFS_W   = 14;
    localparam int SUB_W   = 8;

    localparam logic [5:0] SUB_MAIN  = 6'd0;
    localparam logic [5:0] SUB_PHASE = 6'd1;
    localparam logic [5:0] SUB_CLK   = 6'd2;

    localparam logic [7:0] CFG_MOD_SEG   = 8'h10;
    localparam logic [7:0] CFG_SEQ_SEG   = 8'h11;
    localparam logic [7:0] CFG_SEQ_PAGE  = 8'h12;
    localparam logic [7:0] CFG_DUTY_PAGE = 8'h13;

    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_MOD  = 2'd1,
        RG_DUTY = 2'd2,
        RG_SEQ  = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        TG_NONE, TG_MAIN, TG_PHASE, TG_CLK, TG_MOD, TG_DUTY, TG_SEQ
    } target_e;

    typedef struct packed {
        target_e    tgt;
        logic [3:0] seg;
        logic       err;
    } route_t;

    function automatic logic page_fits(logic [HOST_DW-1:0] v, int w);
        return (v >> w) == '0;
    endfunction

    function automatic logic is_main_read(logic [HOST_DW-1:0] a);
        return (region_e'(a[15:14]) == RG_CTRL) && (a[13:8] == SUB_MAIN);
    endfunction

endpackage

// File: rtl/router_decode.sv
module router_decode
    import router_pkg::*;
#(
    parameter int NUM_SEG     = 2,
    parameter int SEQ_PAGE_W  = 4,
    parameter int DUTY_PAGE_W = 1,
    localparam int DUTY_AW    = OFS_W + DUTY_PAGE_W,
    localparam int SEQ_AW     = OFS_W + SEQ_PAGE_W
) (
    input  logic [HOST_DW-1:0] addr,
    input  logic [HOST_DW-1:0] mod_seg,
    input  logic [HOST_DW-1:0] seq_seg,
    input  logic [HOST_DW-1:0] seq_page,
    input  logic [HOST_DW-1:0] duty_page,
    output route_t             route,
    output logic [SUB_W-1:0]   sub_a,
    output logic [OFS_W-1:0]   mod_a,
    output logic [DUTY_AW-1:0] duty_a,
    output logic [SEQ_AW-1:0]  seq_a
);
    logic [OFS_W-1:0] ofs;

    assign ofs    = addr[OFS_W-1:0];
    assign sub_a  = ofs[SUB_W-1:0];
    assign mod_a  = ofs;
    assign duty_a = {duty_page[DUTY_PAGE_W-1:0], ofs};
    assign seq_a  = {seq_page[SEQ_PAGE_W-1:0], ofs};

    always_comb begin
        route     = '0;
        route.tgt = TG_NONE;
        unique case (region_e'(addr[15:14]))
            RG_CTRL: begin
                case (ofs[13:8])
                    SUB_MAIN:  route.tgt = TG_MAIN;
                    SUB_PHASE: route.tgt = TG_PHASE;
                    SUB_CLK:   route.tgt = TG_CLK;
                    default:   route.err = 1'b1;
                endcase
            end
            RG_MOD: begin
                if (mod_seg < HOST_DW'(NUM_SEG)) begin
                    route.tgt = TG_MOD;
                    route.seg = mod_seg[3:0];
                end else begin
                    route.err = 1'b1;
                end
            end
            RG_DUTY: begin
                if (page_fits(duty_page, DUTY_PAGE_W)) route.tgt = TG_DUTY;
                else                                   route.err = 1'b1;
            end
            RG_SEQ: begin
                if (seq_seg < HOST_DW'(NUM_SEG) && page_fits(seq_page, SEQ_PAGE_W)) begin
                    route.tgt = TG_SEQ;
                    route.seg = seq_seg[3:0];
                end else begin
                    route.err = 1'b1;
                end
            end
            default: route.err = 1'b1;
        endcase
    end
endmodule

// File: rtl/router_ctrl_regs.sv
module router_ctrl_regs
    import router_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [HOST_DW-1:0] wdata,
    input  logic               rd_en,
    input  logic               rd_hit,
    input  logic [IDX_W-1:0]   raddr,
    output logic [HOST_DW-1:0] rdata,
    output logic               rvalid,
    output logic [HOST_DW-1:0] mod_seg,
    output logic [HOST_DW-1:0] seq_seg,
    output logic [HOST_DW-1:0] seq_page,
    output logic [HOST_DW-1:0] duty_page
);
    logic [HOST_DW-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= (rd_en && rd_hit) ? regs[raddr] : '0;
        end
    end

    assign mod_seg   = regs[IDX_W'(CFG_MOD_SEG)];
    assign seq_seg   = regs[IDX_W'(CFG_SEQ_SEG)];
    assign seq_page  = regs[IDX_W'(CFG_SEQ_PAGE)];
    assign duty_page = regs[IDX_W'(CFG_DUTY_PAGE)];
endmodule

// File: rtl/router_out_stage.sv
module router_out_stage
    import router_pkg::*;
#(
    parameter int NUM_SEG  = 2,
    parameter int DUTY_AW  = 15,
    parameter int SEQ_AW   = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  route_t             route,
    input  logic [HOST_DW-1:0] wdata,
    input  logic [SUB_W-1:0]   sub_a,
    input  logic [OFS_W-1:0]   mod_a,
    input  logic [DUTY_AW-1:0] duty_a,
    input  logic [SEQ_AW-1:0]  seq_a,
    output logic               phase_we,
    output logic               clkcfg_we,
    output logic [SUB_W-1:0]   sub_addr,
    output logic [NUM_SEG-1:0] mod_we,
    output logic [OFS_W-1:0]   mod_addr,
    output logic               duty_we,
    output logic [DUTY_AW-1:0] duty_addr,
    output logic [NUM_SEG-1:0] seq_we,
    output logic [SEQ_AW-1:0]  seq_addr,
    output logic [HOST_DW-1:0] mem_wdata,
    output logic               wr_error
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_we  <= 1'b0;
            clkcfg_we <= 1'b0;
            duty_we   <= 1'b0;
            wr_error  <= 1'b0;
            sub_addr  <= '0;
            mod_addr  <= '0;
            duty_addr <= '0;
            seq_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            phase_we  <= wr_en && route.tgt == TG_PHASE;
            clkcfg_we <= wr_en && route.tgt == TG_CLK;
            duty_we   <= wr_en && route.tgt == TG_DUTY;
            wr_error  <= wr_error | (wr_en & route.err);
            if (wr_en) begin
                sub_addr  <= sub_a;
                mod_addr  <= mod_a;
                duty_addr <= duty_a;
                seq_addr  <= seq_a;
                mem_wdata <= wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                mod_we[g] <= 1'b0;
                seq_we[g] <= 1'b0;
            end else begin
                mod_we[g] <= wr_en && route.tgt == TG_MOD && route.seg == 4'(g);
                seq_we[g] <= wr_en && route.tgt == TG_SEQ && route.seg == 4'(g);
            end
        end
    end
endmodule

// File: rtl/bram_write_router.sv
module bram_write_router
    import router_pkg::*;
#(
    parameter int NUM_SEG     = 2,
    parameter int SEQ_PAGE_W  = 4,
    parameter int DUTY_PAGE_W = 1,
    parameter int REG_DEPTH   = 256,
    localparam int DUTY_AW    = OFS_W + DUTY_PAGE_W,
    localparam int SEQ_AW     = OFS_W + SEQ_PAGE_W,
    localparam int IDX_W      = $clog2(REG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [15:0]        host_addr,
    input  logic [15:0]        host_wdata,
    output logic [15:0]        host_rdata,
    output logic               host_rvalid,
    output logic               phase_we,
    output logic               clkcfg_we,
    output logic [7:0]         sub_addr,
    output logic [NUM_SEG-1:0] mod_we,
    output logic [13:0]        mod_addr,
    output logic               duty_we,
    output logic [DUTY_AW-1:0] duty_addr,
    output logic [NUM_SEG-1:0] seq_we,
    output logic [SEQ_AW-1:0]  seq_addr,
    output logic [15:0]        mem_wdata,
    output logic               wr_error
);
    route_t             route;
    logic [HOST_DW-1:0] mod_seg, seq_seg, seq_page, duty_page;
    logic [SUB_W-1:0]   sub_a;
    logic [OFS_W-1:0]   mod_a;
    logic [DUTY_AW-1:0] duty_a;
    logic [SEQ_AW-1:0]  seq_a;
    logic               main_we;

    assign main_we = host_wr_en && route.tgt == TG_MAIN;

    router_decode #(
        .NUM_SEG(NUM_SEG), .SEQ_PAGE_W(SEQ_PAGE_W), .DUTY_PAGE_W(DUTY_PAGE_W)
    ) u_dec (
        .addr(host_addr), .mod_seg(mod_seg), .seq_seg(seq_seg),
        .seq_page(seq_page), .duty_page(duty_page), .route(route),
        .sub_a(sub_a), .mod_a(mod_a), .duty_a(duty_a), .seq_a(seq_a)
    );

    router_ctrl_regs #(.DEPTH(REG_DEPTH)) u_regs (
        .clk(clk), .rst(rst), .we(main_we), .waddr(host_addr[IDX_W-1:0]),
        .wdata(host_wdata), .rd_en(host_rd_en), .rd_hit(is_main_read(host_addr)),
        .raddr(host_addr[IDX_W-1:0]), .rdata(host_rdata), .rvalid(host_rvalid),
        .mod_seg(mod_seg), .seq_seg(seq_seg), .seq_page(seq_page), .duty_page(duty_page)
    );

    router_out_stage #(
        .NUM_SEG(NUM_SEG), .DUTY_AW(DUTY_AW), .SEQ_AW(SEQ_AW)
    ) u_out (
        .clk(clk), .rst(rst), .wr_en(host_wr_en), .route(route), .wdata(host_wdata),
        .sub_a(sub_a), .mod_a(mod_a), .duty_a(duty_a), .seq_a(seq_a),
        .phase_we(phase_we), .clkcfg_we(clkcfg_we), .sub_addr(sub_addr),
        .mod_we(mod_we), .mod_addr(mod_addr), .duty_we(duty_we), .duty_addr(duty_addr),
        .seq_we(seq_we), .seq_addr(seq_addr), .mem_wdata(mem_wdata), .wr_error(wr_error)
    );
endmodule

// File: rtl/router_chk.sv
module router_chk #(
    parameter int NUM_SEG = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               host_wr_en,
    input logic               host_rd_en,
    input logic [15:0]        host_addr,
    input logic               host_rvalid,
    input logic               phase_we,
    input logic               clkcfg_we,
    input logic [NUM_SEG-1:0] mod_we,
    input logic               duty_we,
    input logic [NUM_SEG-1:0] seq_we,
    input logic               wr_error
);
    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({phase_we, clkcfg_we, mod_we, duty_we, seq_we}) <= 1);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !host_wr_en |=> !(phase_we || clkcfg_we || duty_we || |mod_we || |seq_we));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wr_error |=> wr_error);

    // R7
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd_en |=> host_rvalid);

    // R7
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd_en |=> !host_rvalid);

    // R1
    mod_region_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && host_addr[15:14] == 2'd1)
            |=> !(phase_we || clkcfg_we || duty_we || |seq_we));
endmodule

bind bram_write_router router_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_rvalid(host_rvalid), .phase_we(phase_we),
    .clkcfg_we(clkcfg_we), .mod_we(mod_we), .duty_we(duty_we), .seq_we(seq_we),
    .wr_error(wr_error)
);

// File: tb/sim_bram_write_router.sv
`timescale 1ns/1ps
module sim_bram_write_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic [15:0] host_rdata, mem_wdata;
    logic        host_rvalid, phase_we, clkcfg_we, duty_we, wr_error;
    logic [7:0]  sub_addr;
    logic [1:0]  mod_we, seq_we;
    logic [13:0] mod_addr;
    logic [14:0] duty_addr;
    logic [17:0] seq_addr;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] mreg [256];
    bit err_m;

    always #5 clk = ~clk;

    bram_write_router u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) mreg[i] = '0;
        err_m = 0;
    endtask

    // expected strobes {phase,clk,mod[1:0],duty,seq[1:0]} and target address
    function automatic void expect_wr(input logic [15:0] a, output logic [6:0] st,
                                      output logic [31:0] ea, output bit er);
        logic [13:0] ofs = a[13:0];
        st = '0; ea = '0; er = 0;
        case (a[15:14])
            2'd0: case (a[13:8])
                6'd0: ;
                6'd1: begin st = 7'b1000000; ea = 32'(a[7:0]); end
                6'd2: begin st = 7'b0100000; ea = 32'(a[7:0]); end
                default: er = 1;
            endcase
            2'd1: if (mreg[8'h10] < 2) begin
                st = (mreg[8'h10] == 0) ? 7'b0001000 : 7'b0010000; ea = 32'(ofs);
            end else er = 1;
            2'd2: if (mreg[8'h13] < 2) begin
                st = 7'b0000100; ea = mreg[8'h13] * 32'd16384 + 32'(ofs);
            end else er = 1;
            default: if (mreg[8'h11] < 2 && mreg[8'h12] < 16) begin
                st = (mreg[8'h11] == 0) ? 7'b0000001 : 7'b0000010;
                ea = mreg[8'h12] * 32'd16384 + 32'(ofs);
            end else er = 1;
        endcase
    endfunction

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input string req);
        logic [6:0] st; logic [31:0] ea, act_a; bit er;
        expect_wr(a, st, ea, er);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        err_m = err_m | er;
        check(req, {25'b0, phase_we, clkcfg_we, mod_we, duty_we, seq_we}, {25'b0, st});
        check(req, 32'(wr_error), 32'(err_m));
        if (st != 0) begin
            act_a = (phase_we | clkcfg_we) ? 32'(sub_addr) : |mod_we ? 32'(mod_addr) :
                    duty_we ? 32'(duty_addr) : 32'(seq_addr);
            check(req, act_a, ea);
            check(req, 32'(mem_wdata), 32'(d));
        end
        if (a[15:8] == 8'h00) mreg[a[7:0]] = d;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        check(req, 32'(host_rvalid), 32'd1);
        check(req, 32'(host_rdata), (a[15:8] == 8'h00) ? 32'(mreg[a[7:0]]) : 32'd0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        if (!done) $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R11 reset state
        check("R11", {27'b0, phase_we, clkcfg_we, duty_we, |mod_we, |seq_we}, 32'd0);
        check("R11", 32'(wr_error), 32'd0);
        check("R11", 32'(host_rvalid), 32'd0);
        rd(16'h0010, "R11");
        // R2 sub-tables
        wr(16'h0105, 16'hA1A1, "R2");
        wr(16'h02FE, 16'hB2B2, "R2");
        // R3 main file write and readback
        wr(16'h0042, 16'h5A5A, "R3");
        rd(16'h0042, "R3");
        // R4 modulation buffer 0, then R10 switch takes effect next cycle
        wr(16'h4123, 16'h1111, "R4");
        wr(16'h0010, 16'h0001, "R4");
        wr(16'h7FFF, 16'h2222, "R10");
        // R6 duty page
        wr(16'h0013, 16'h0001, "R6");
        wr(16'h8ABC, 16'h3333, "R6");
        // R5 sequence buffer/page
        wr(16'h0011, 16'h0001, "R5");
        wr(16'h0012, 16'h000F, "R5");
        wr(16'hFFFF, 16'h4444, "R5");
        wr(16'h0012, 16'h0005, "R10");
        wr(16'hC001, 16'h5555, "R10");
        // R7 reads of non-main regions return zero
        rd(16'h4000, "R7");
        rd(16'h0105, "R7");
        @(negedge clk);
        check("R7", 32'(host_rvalid), 32'd0);
        // R8 undefined sub-table, stickiness
        wr(16'h0300, 16'h6666, "R8");
        wr(16'h0101, 16'h7777, "R8");
        do_reset();
        check("R8", 32'(wr_error), 32'd0);
        wr(16'h0010, 16'h0002, "R8");
        wr(16'h4001, 16'h8888, "R8");
        do_reset();
        wr(16'h0012, 16'h0010, "R8");
        wr(16'hC002, 16'h9999, "R8");
        wr(16'h0013, 16'h0002, "R8");
        wr(16'h8002, 16'h9999, "R8");
        do_reset();
        // R1 random mix across regions
        for (int i = 0; i < 400; i++) begin
            int k = $urandom % 8;
            logic [15:0] a;
            case (k)
                0: wr(16'h0010 + 16'($urandom % 2), 16'($urandom % 3), "R1");
                1: wr(16'h0012 + 16'($urandom % 2), 16'($urandom % 18), "R1");
                2, 3: begin
                    a = 16'($urandom);
                    if (a[15:14] == 2'd0) a[15:14] = 2'd3;
                    wr(a, 16'($urandom), "R1");
                end
                4: begin
                    a = {2'b00, 6'($urandom % 4), 8'($urandom)};
                    if (a[13:8] == 6'd0 && a[7:4] == 4'h1) a[7:4] = 4'h2;
                    wr(a, 16'($urandom), "R2");
                end
                5: rd(16'($urandom % 512), "R7");
                default: begin
                    a = {8'h00, 8'($urandom)};
                    if (a[7:4] == 4'h1) a[7:4] = 4'h3;
                    wr(a, 16'($urandom), "R3");
                end
            endcase
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule